// File: doc/BRIEF.md
# External Interrupt and Event Controller

This block gathers 32 external request lines and turns them into interrupt and event outputs for two processor cores, plus one wakeup request per line for a low-power domain. A simple single-cycle register bus sets it up. Each line is fixed at build time as either configurable or direct. A configurable line runs its own edge detector. That detector sets one pending flag per core, and software clears the flag. A direct line passes its input level straight through and has no pending flag.

Lines 0 to 15 each take pin n from one of several GPIO ports, and a 4-bit select field per line picks the port. Lines 16 to 31 come from a separate auxiliary input bus. Software can raise the request of any configurable line. Each core clears its own pending flags by writing ones. The wakeup request of a line clears in one of two ways. In automatic mode it clears by itself after a fixed delay, or when the direct input drops. In held mode it stays set until one of four external clear events, chosen per line, arrives.

Top module: `extint_ctrl`

Register word addresses: 0 rising enable, 1 falling enable, 2 software trigger, 3 core-1 interrupt mask, 4 core-1 event mask, 5 core-1 pending, 6 core-2 interrupt mask, 7 core-2 event mask, 8 core-2 pending, 9 wakeup mode, 10 wakeup clear code for lines 0-15, 11 wakeup clear code for lines 16-31, 12 to 15 port select. In every per-line register, bit n belongs to line n.

## Requirements
- R1: On a configurable line, bit n of register 0 enables rising edges and bit n of register 1 enables falling edges. With both set, either transition is detected. A change at the input sets the pending flag at the second rising clock edge after the change. A transition whose enable is clear sets nothing.
- R2: A pending flag of a core is set only for lines whose interrupt-mask bit for that core is 1. Each core's irq output is the OR over all lines of pending AND interrupt mask. For a direct line the synchronized input level takes the place of the pending flag, so irq follows that level one clock after the input changes.
- R3: Core 2 has its own interrupt mask (6), event mask (7) and pending register (8). Clearing a flag for one core leaves the other core's flag and irq untouched.
- R4: Writing 1 to bit n of a pending register clears line n's flag, and writing 0 has no effect. If a detection and a clear land on the same clock edge, the flag stays set.
- R5: Writing 1 to bit n of register 2 sets line n's pending flag (where masked) on that same write edge, as if an enabled edge had occurred. Register 2 reads as 0, and such a write to a direct line sets no flag.
- R6: Port select registers 12+line/4 hold a 4-bit port number for lines 0-15, with the field at bit 4*(line mod 4). Pin n of the selected port drives line n, and pins of other ports are ignored.
- R7: Lines 24-31 are direct: their rising, falling and trigger bits read 0 whatever is written, and they never show a pending flag. Event-mask bits exist only for lines 0-27, and the others read 0.
- R8: An event output is a pulse one clock long. It fires one clock after a detected edge on a line whose event-mask bit is set for that core. A direct line counts its rising edge as the detected edge.
- R9: With wakeup mode bit 0 (automatic), a configurable line's wakeup request rises together with the pending flag and stays high for exactly WK_DELAY clock cycles. On a direct line the request follows the input, delayed by two clocks.
- R10: With wakeup mode bit 1 (held), the request stays high until clr_evt[code] is seen high at a clock edge. The code is a 2-bit field at bit 2*(line mod 16) of register 10 (lines 0-15) or register 11 (lines 16-31). The other clear inputs have no effect.
- R11: After reset every register reads 0, and all irq, event and wakeup outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 4 | Register word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| gpio_in | input | NPORTS*16 | GPIO ports, port p pin n at bit 16*p+n |
| aux_in | input | 16 | Inputs of lines 16-31 |
| clr_evt | input | 4 | External wakeup clear events, indexed by code |
| irq_c1 | output | 1 | Core 1 interrupt |
| irq_c2 | output | 1 | Core 2 interrupt |
| evt_c1 | output | 1 | Core 1 event pulse |
| evt_c2 | output | 1 | Core 2 event pulse |
| wk_req | output | 32 | Per-line wakeup request |

## Verification
The edge detector gets several patterns. A rising-only line receives a falling transition, to show that edge direction matters. A both-edges line receives each polarity in turn. A detection is made to coincide with a clear write, to show whether set or clear wins. Software triggers go to a configurable line and to a direct line, which separates the trigger path from the level path. Port selection is tested by driving the same pin number on an unselected port and then on the selected one. The wakeup checks time the automatic release cycle by cycle and send non-matching clear codes before the matching one.

// File: rtl/extint_pkg.sv
package extint_pkg;
    localparam int NLINES = 32;
    localparam int NGPIO  = 16;
    localparam int SELW   = 4;
    localparam int CODEW  = 2;
    localparam int NCLR   = 1 << CODEW;
    localparam int AW     = 4;
    localparam int DW     = 32;

    typedef enum logic [AW-1:0] {
        RG_RISE    = 4'd0,
        RG_FALL    = 4'd1,
        RG_SWTRIG  = 4'd2,
        RG_IMASK1  = 4'd3,
        RG_EMASK1  = 4'd4,
        RG_PEND1   = 4'd5,
        RG_IMASK2  = 4'd6,
        RG_EMASK2  = 4'd7,
        RG_PEND2   = 4'd8,
        RG_WKMODE  = 4'd9,
        RG_WKSELLO = 4'd10,
        RG_WKSELHI = 4'd11,
        RG_PSEL0   = 4'd12,
        RG_PSEL1   = 4'd13,
        RG_PSEL2   = 4'd14,
        RG_PSEL3   = 4'd15
    } reg_idx_e;

    typedef struct packed {
        logic [NLINES-1:0] rise;
        logic [NLINES-1:0] fall;
        logic [NLINES-1:0] imask1;
        logic [NLINES-1:0] emask1;
        logic [NLINES-1:0] imask2;
        logic [NLINES-1:0] emask2;
        logic [NLINES-1:0] wkmode;
        logic [DW-1:0]     wksel_lo;
        logic [DW-1:0]     wksel_hi;
    } cfg_t;

    // Clear-event code of a line: low register for lines 0-15, high otherwise.
    function automatic logic [CODEW-1:0] wk_code(input cfg_t c, input int line);
        int pos;
        pos = CODEW * (line % 16);
        if (line < 16) return c.wksel_lo[pos +: CODEW];
        else           return c.wksel_hi[pos +: CODEW];
    endfunction
endpackage

// File: rtl/extint_regs.sv
module extint_regs
    import extint_pkg::*;
#(
    parameter logic [NLINES-1:0] CFG_CAP = 32'h00FF_FFFF,
    parameter logic [NLINES-1:0] EVT_CAP = 32'h0FFF_FFFF
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  we,
    input  logic [AW-1:0]         addr,
    input  logic [DW-1:0]         wdata,
    input  logic [NLINES-1:0]     pend1,
    input  logic [NLINES-1:0]     pend2,
    output cfg_t                  cfg,
    output logic [NLINES-1:0]     sw_vec,
    output logic [NLINES-1:0]     clr1,
    output logic [NLINES-1:0]     clr2,
    output logic [NGPIO*SELW-1:0] psel,
    output logic [DW-1:0]         rdata
);
    localparam int NPSEL = NGPIO / 4;

    cfg_t cfg_q;
    logic [NPSEL-1:0][4*SELW-1:0] psel_q;
    reg_idx_e idx;

    assign idx  = reg_idx_e'(addr);
    assign cfg  = cfg_q;
    assign psel = psel_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q  <= '0;
            psel_q <= '0;
        end else if (we) begin
            case (idx)
                RG_RISE:    cfg_q.rise     <= wdata & CFG_CAP;
                RG_FALL:    cfg_q.fall     <= wdata & CFG_CAP;
                RG_IMASK1:  cfg_q.imask1   <= wdata;
                RG_EMASK1:  cfg_q.emask1   <= wdata & EVT_CAP;
                RG_IMASK2:  cfg_q.imask2   <= wdata;
                RG_EMASK2:  cfg_q.emask2   <= wdata & EVT_CAP;
                RG_WKMODE:  cfg_q.wkmode   <= wdata;
                RG_WKSELLO: cfg_q.wksel_lo <= wdata;
                RG_WKSELHI: cfg_q.wksel_hi <= wdata;
                RG_PSEL0, RG_PSEL1, RG_PSEL2, RG_PSEL3:
                    psel_q[addr[1:0]] <= wdata[4*SELW-1:0];
                default: ;
            endcase
        end
    end

    // Strobes that act only on the write edge.
    assign sw_vec = (we && idx == RG_SWTRIG) ? (wdata & CFG_CAP) : '0;
    assign clr1   = (we && idx == RG_PEND1)  ? wdata : '0;
    assign clr2   = (we && idx == RG_PEND2)  ? wdata : '0;

    always_comb begin
        case (idx)
            RG_RISE:    rdata = cfg_q.rise;
            RG_FALL:    rdata = cfg_q.fall;
            RG_IMASK1:  rdata = cfg_q.imask1;
            RG_EMASK1:  rdata = cfg_q.emask1;
            RG_PEND1:   rdata = pend1;
            RG_IMASK2:  rdata = cfg_q.imask2;
            RG_EMASK2:  rdata = cfg_q.emask2;
            RG_PEND2:   rdata = pend2;
            RG_WKMODE:  rdata = cfg_q.wkmode;
            RG_WKSELLO: rdata = cfg_q.wksel_lo;
            RG_WKSELHI: rdata = cfg_q.wksel_hi;
            RG_PSEL0, RG_PSEL1, RG_PSEL2, RG_PSEL3:
                rdata = {{(DW-4*SELW){1'b0}}, psel_q[addr[1:0]]};
            default:    rdata = '0;
        endcase
    end

    // R7: lines without the capability never hold trigger or event-mask bits
    p_cap_r7: assert property (@(posedge clk) disable iff (rst)
        ((cfg_q.rise | cfg_q.fall) & ~CFG_CAP) == '0 && ((cfg_q.emask1 | cfg_q.emask2) & ~EVT_CAP) == '0);
endmodule

// File: rtl/extint_portmux.sv
module extint_portmux
    import extint_pkg::*;
#(
    parameter int NPORTS = 4
) (
    input  logic [NPORTS*NGPIO-1:0] gpio_in,
    input  logic [NGPIO*SELW-1:0]   psel,
    output logic [NGPIO-1:0]        line_in
);
    for (genvar i = 0; i < NGPIO; i++) begin : g_pin
        always_comb begin
            line_in[i] = 1'b0;
            for (int p = 0; p < NPORTS; p++) begin
                if (psel[SELW*i +: SELW] == SELW'(p)) line_in[i] = gpio_in[NGPIO*p + i];
            end
        end
    end
endmodule

// File: rtl/extint_line.sv
module extint_line
    import extint_pkg::*;
#(
    parameter bit IS_CFG   = 1'b1,
    parameter int WK_DELAY = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             raw,
    input  logic             rise_en,
    input  logic             fall_en,
    input  logic             sw,
    input  logic             im1,
    input  logic             em1,
    input  logic             im2,
    input  logic             em2,
    input  logic             clr1,
    input  logic             clr2,
    input  logic             wkmode,
    input  logic [CODEW-1:0] wkcode,
    input  logic [NCLR-1:0]  clr_evt,
    output logic             pend1,
    output logic             pend2,
    output logic             irq1,
    output logic             irq2,
    output logic             evt1,
    output logic             evt2,
    output logic             wk
);
    localparam int CW = $clog2(WK_DELAY + 1);

    logic s_q, s_p, rise_det, evt_src;

    always_ff @(posedge clk) begin
        if (rst) begin
            s_q <= 1'b0;
            s_p <= 1'b0;
        end else begin
            s_q <= raw;
            s_p <= s_q;
        end
    end
    assign rise_det = s_q & ~s_p;

    always_ff @(posedge clk) begin
        if (rst) begin
            evt1 <= 1'b0;
            evt2 <= 1'b0;
        end else begin
            evt1 <= evt_src & em1;
            evt2 <= evt_src & em2;
        end
    end

    if (IS_CFG) begin : g_cfg
        logic trig, fall_det;
        logic [CW-1:0] cnt;

        assign fall_det = ~s_q & s_p;
        assign trig     = (rise_det & rise_en) | (fall_det & fall_en) | sw;
        assign evt_src  = trig;

        always_ff @(posedge clk) begin
            if (rst) begin
                pend1 <= 1'b0;
                pend2 <= 1'b0;
            end else begin
                pend1 <= (pend1 & ~clr1) | (trig & im1);
                pend2 <= (pend2 & ~clr2) | (trig & im2);
            end
        end
        assign irq1 = pend1 & im1;
        assign irq2 = pend2 & im2;

        always_ff @(posedge clk) begin
            if (rst) begin
                wk  <= 1'b0;
                cnt <= '0;
            end else if (trig) begin
                wk  <= 1'b1;
                cnt <= wkmode ? '0 : CW'(WK_DELAY);
            end else if (wk) begin
                if (!wkmode) begin
                    if (cnt <= CW'(1)) begin
                        wk  <= 1'b0;
                        cnt <= '0;
                    end else begin
                        cnt <= cnt - CW'(1);
                    end
                end else if (clr_evt[wkcode]) begin
                    wk <= 1'b0;
                end
            end
        end

        p_pend_set_r1: assert property (@(posedge clk) disable iff (rst)
            (trig && im1) |=> pend1);
        p_w1c_r4: assert property (@(posedge clk) disable iff (rst)
            (clr1 && !(trig && im1)) |=> !pend1);
        p_wk_auto_r9: assert property (@(posedge clk) disable iff (rst)
            (!wkmode && wk && cnt == CW'(1) && !trig) |=> !wk);
        p_wk_hold_r10: assert property (@(posedge clk) disable iff (rst)
            (wkmode && wk && !trig && !clr_evt[wkcode]) |=> wk);
    end else begin : g_dir
        logic unused_dir;
        assign unused_dir = ^{rise_en, fall_en, sw, clr1, clr2};
        assign evt_src = rise_det;
        assign pend1   = 1'b0;
        assign pend2   = 1'b0;
        assign irq1    = s_q & im1;
        assign irq2    = s_q & im2;

        always_ff @(posedge clk) begin
            if (rst)                     wk <= 1'b0;
            else if (!wkmode)            wk <= s_q;
            else if (s_q)                wk <= 1'b1;
            else if (clr_evt[wkcode])    wk <= 1'b0;
        end
    end
endmodule

// File: rtl/extint_ctrl.sv
module extint_ctrl
    import extint_pkg::*;
#(
    parameter int                NPORTS   = 4,
    parameter int                WK_DELAY = 4,
    parameter logic [NLINES-1:0] CFG_CAP  = 32'h00FF_FFFF,
    parameter logic [NLINES-1:0] EVT_CAP  = 32'h0FFF_FFFF
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     bus_we,
    input  logic [AW-1:0]            bus_addr,
    input  logic [DW-1:0]            bus_wdata,
    output logic [DW-1:0]            bus_rdata,
    input  logic [NPORTS*NGPIO-1:0]  gpio_in,
    input  logic [NLINES-NGPIO-1:0]  aux_in,
    input  logic [NCLR-1:0]          clr_evt,
    output logic                     irq_c1,
    output logic                     irq_c2,
    output logic                     evt_c1,
    output logic                     evt_c2,
    output logic [NLINES-1:0]        wk_req
);
    cfg_t cfg;
    logic [NLINES-1:0] sw_v, clr1_v, clr2_v, pend1_v, pend2_v;
    logic [NLINES-1:0] irq1_v, irq2_v, evt1_v, evt2_v;
    logic [NGPIO*SELW-1:0] psel;
    logic [NGPIO-1:0] mux_out;

    extint_regs #(.CFG_CAP(CFG_CAP), .EVT_CAP(EVT_CAP)) u_regs (
        .clk(clk), .rst(rst), .we(bus_we), .addr(bus_addr), .wdata(bus_wdata),
        .pend1(pend1_v), .pend2(pend2_v), .cfg(cfg), .sw_vec(sw_v),
        .clr1(clr1_v), .clr2(clr2_v), .psel(psel), .rdata(bus_rdata)
    );

    extint_portmux #(.NPORTS(NPORTS)) u_mux (
        .gpio_in(gpio_in), .psel(psel), .line_in(mux_out)
    );

    for (genvar i = 0; i < NLINES; i++) begin : g_line
        logic raw_i;
        if (i < NGPIO) begin : g_gp
            assign raw_i = mux_out[i];
        end else begin : g_aux
            assign raw_i = aux_in[i-NGPIO];
        end

        extint_line #(.IS_CFG(CFG_CAP[i]), .WK_DELAY(WK_DELAY)) u_line (
            .clk(clk), .rst(rst), .raw(raw_i),
            .rise_en(cfg.rise[i]), .fall_en(cfg.fall[i]), .sw(sw_v[i]),
            .im1(cfg.imask1[i]), .em1(cfg.emask1[i]),
            .im2(cfg.imask2[i]), .em2(cfg.emask2[i]),
            .clr1(clr1_v[i]), .clr2(clr2_v[i]),
            .wkmode(cfg.wkmode[i]), .wkcode(wk_code(cfg, i)), .clr_evt(clr_evt),
            .pend1(pend1_v[i]), .pend2(pend2_v[i]),
            .irq1(irq1_v[i]), .irq2(irq2_v[i]),
            .evt1(evt1_v[i]), .evt2(evt2_v[i]), .wk(wk_req[i])
        );
    end

    assign irq_c1 = |irq1_v;
    assign irq_c2 = |irq2_v;
    assign evt_c1 = |evt1_v;
    assign evt_c2 = |evt2_v;

    // R5: a software trigger on masked configurable lines leaves their flags set
    p_sw_r5: assert property (@(posedge clk) disable iff (rst)
        (|(sw_v & cfg.imask1)) |=>
        ((pend1_v & $past(sw_v & cfg.imask1)) == $past(sw_v & cfg.imask1)));
    // R7: direct lines never report a pending flag to either core
    p_dir_nopend_r7: assert property (@(posedge clk) disable iff (rst)
        ((pend1_v | pend2_v) & ~CFG_CAP) == '0);
    // R11: outputs are quiet in the first cycle after reset
    p_reset_quiet_r11: assert property (@(posedge clk)
        $fell(rst) |-> (!irq_c1 && !irq_c2 && !evt_c1 && !evt_c2 && wk_req == '0));
endmodule

// File: tb/extint_ctrl_test.sv
module extint_ctrl_test;
    localparam int CLK_PERIOD = 10;
    localparam int NP = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_we = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [NP*16-1:0] gpio_in = '0;
    logic [15:0] aux_in = '0;
    logic [3:0]  clr_evt = '0;
    logic irq_c1, irq_c2, evt_c1, evt_c2;
    logic [31:0] wk_req;

    extint_ctrl uut (
        .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .gpio_in(gpio_in),
        .aux_in(aux_in), .clr_evt(clr_evt), .irq_c1(irq_c1), .irq_c2(irq_c2),
        .evt_c1(evt_c1), .evt_c2(evt_c2), .wk_req(wk_req)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    typedef struct {
        string       req;
        int          src;
        logic [31:0] exp;
    } item_t;

    item_t q[$];
    event chk_ev;
    int checks = 0;
    int fails = 0;
    logic [31:0] rd_val = '0;
    bit done = 0;

    // src: 0 last read, 1 irq_c1, 2 irq_c2, 3 evt_c1, 4 evt_c2, 5 wk_req
    function automatic logic [31:0] obs(input int s);
        case (s)
            0: return rd_val;
            1: return {31'b0, irq_c1};
            2: return {31'b0, irq_c2};
            3: return {31'b0, evt_c1};
            4: return {31'b0, evt_c2};
            default: return wk_req;
        endcase
    endfunction

    // Monitor: pops expected items and compares with the observed output
    initial begin
        forever begin
            @(chk_ev);
            while (q.size() > 0) begin
                item_t it;
                logic [31:0] act;
                it = q.pop_front();
                act = obs(it.src);
                checks++;
                if (act !== it.exp) begin
                    fails++;
                    $display("FAIL %s src=%0d actual=%h expected=%h", it.req, it.src, act, it.exp);
                end
            end
        end
    end

    task automatic expect_val(input string req, input int src, input logic [31:0] e);
        item_t it;
        it.req = req; it.src = src; it.exp = e;
        q.push_back(it);
        ->chk_ev;
        #1;
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a);
        @(negedge clk);
        bus_addr = a;
        #1;
        rd_val = bus_rdata;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        tick(3);
        rst = 1'b0;

        // R11: reset state
        expect_val("R11 irq_c1", 1, 0);
        expect_val("R11 wk_req", 5, 0);
        for (int a = 0; a < 16; a++) begin
            rd(4'(a));
            expect_val("R11 register reset", 0, 0);
        end

        // R1 R2 R8: rising edge on line 3, port 0
        wr(4'd0, 32'h8);
        wr(4'd3, 32'h8);
        wr(4'd4, 32'h8);
        @(negedge clk); gpio_in[3] = 1'b1;
        tick(2);
        expect_val("R1 rising sets pending / R2 irq", 1, 1);
        expect_val("R8 event pulse", 3, 1);
        tick(1);
        expect_val("R8 event lasts one cycle", 3, 0);
        rd(4'd5);
        expect_val("R1 pending readback", 0, 32'h8);
        wr(4'd5, 32'h8);
        expect_val("R4 clear by write one", 1, 0);
        @(negedge clk); gpio_in[3] = 1'b0;
        tick(2);
        expect_val("R1 falling ignored when disabled", 1, 0);

        // R1 R4: both edges, write-zero, set/clear collision
        wr(4'd1, 32'h8);
        @(negedge clk); gpio_in[3] = 1'b1;
        tick(2);
        expect_val("R1 both-edge rising", 1, 1);
        wr(4'd5, 32'h0);
        expect_val("R4 write zero no effect", 1, 1);
        wr(4'd5, 32'h8);
        @(negedge clk); gpio_in[3] = 1'b0;
        tick(2);
        expect_val("R1 both-edge falling", 1, 1);
        wr(4'd5, 32'h8);
        @(negedge clk); gpio_in[3] = 1'b1;
        wr(4'd5, 32'h8);
        rd(4'd5);
        expect_val("R4 set wins over same-cycle clear", 0, 32'h8);
        wr(4'd5, 32'h8);
        expect_val("R4 cleared after collision", 1, 0);

        // R3: second core
        wr(4'd6, 32'h8);
        @(negedge clk); gpio_in[3] = 1'b0;
        tick(2);
        expect_val("R3 core1 irq", 1, 1);
        expect_val("R3 core2 irq", 2, 1);
        wr(4'd5, 32'h8);
        expect_val("R3 core1 cleared", 1, 0);
        expect_val("R3 core2 untouched", 2, 1);
        rd(4'd8);
        expect_val("R3 core2 pending readback", 0, 32'h8);
        wr(4'd8, 32'h8);
        expect_val("R3 core2 cleared", 2, 0);

        // R5: software trigger
        wr(4'd3, 32'h1010_0008);
        wr(4'd2, 32'h0010_0000);
        rd(4'd5);
        expect_val("R5 sw trigger sets pending", 0, 32'h0010_0000);
        rd(4'd2);
        expect_val("R5 trigger register reads zero", 0, 0);
        wr(4'd5, 32'h0010_0000);
        wr(4'd2, 32'h1000_0000);
        rd(4'd5);
        expect_val("R5 sw trigger ignored on direct line", 0, 0);
        expect_val("R5 no irq from direct sw trigger", 1, 0);

        // R2 R7: direct line 28 level path
        @(negedge clk); aux_in[12] = 1'b1;
        tick(1);
        expect_val("R2 direct level irq", 1, 1);
        rd(4'd5);
        expect_val("R7 direct line no pending", 0, 0);
        @(negedge clk); aux_in[12] = 1'b0;
        tick(1);
        expect_val("R2 direct level released", 1, 0);

        // R7: capability masks
        wr(4'd0, 32'hFFFF_FFFF);
        rd(4'd0);
        expect_val("R7 rising bits only configurable", 0, 32'h00FF_FFFF);
        wr(4'd4, 32'hFFFF_FFFF);
        rd(4'd4);
        expect_val("R7 event mask only capable lines", 0, 32'h0FFF_FFFF);
        wr(4'd0, 32'h0);
        wr(4'd1, 32'h0);
        wr(4'd4, 32'h0);

        // R6: port selection
        wr(4'd12, 32'h0000_0200);
        wr(4'd0, 32'h4);
        wr(4'd3, 32'h4);
        @(negedge clk); gpio_in[2] = 1'b1;
        tick(2);
        expect_val("R6 unselected port ignored", 1, 0);
        @(negedge clk); gpio_in[34] = 1'b1;
        tick(2);
        expect_val("R6 selected port drives line", 1, 1);
        wr(4'd5, 32'h4);
        wr(4'd15, 32'h0000_0010);
        wr(4'd0, 32'h2000);
        wr(4'd3, 32'h2000);
        @(negedge clk); gpio_in[29] = 1'b1;
        tick(2);
        expect_val("R6 line 13 from port 1", 1, 1);
        wr(4'd5, 32'h2000);
        rd(4'd15);
        expect_val("R6 select readback", 0, 32'h10);

        // R9: automatic wakeup release
        wr(4'd0, 32'h8);
        @(negedge clk); gpio_in[3] = 1'b0;
        tick(1);
        @(negedge clk); gpio_in[3] = 1'b1;
        tick(2);
        expect_val("R9 wakeup raised", 5, 32'h8);
        tick(3);
        expect_val("R9 wakeup held delay", 5, 32'h8);
        tick(1);
        expect_val("R9 wakeup released after delay", 5, 0);
        @(negedge clk); aux_in[12] = 1'b1;
        tick(2);
        expect_val("R9 direct wakeup follows input", 5, 32'h1000_0000);
        @(negedge clk); aux_in[12] = 1'b0;
        tick(2);
        expect_val("R9 direct wakeup drops", 5, 0);

        // R10: held wakeup with selected clear events
        wr(4'd9, 32'h0010_0020);
        wr(4'd11, 32'h0000_0200);
        wr(4'd2, 32'h0010_0000);
        expect_val("R10 held wakeup raised", 5, 32'h0010_0000);
        @(negedge clk); clr_evt = 4'b0001;
        @(negedge clk); clr_evt = 4'b0000;
        tick(5);
        expect_val("R10 other clear event ignored", 5, 32'h0010_0000);
        @(negedge clk); clr_evt = 4'b0100;
        @(negedge clk); clr_evt = 4'b0000;
        expect_val("R10 selected clear event", 5, 0);
        wr(4'd10, 32'h0000_0C00);
        wr(4'd2, 32'h0000_0020);
        @(negedge clk); clr_evt = 4'b0100;
        @(negedge clk); clr_evt = 4'b0000;
        expect_val("R10 low register code ignores code 2", 5, 32'h20);
        @(negedge clk); clr_evt = 4'b1000;
        @(negedge clk); clr_evt = 4'b0000;
        expect_val("R10 low register code 3 clears", 5, 0);

        // R8 R3: direct line event on core 2
        wr(4'd7, 32'h0200_0000);
        @(negedge clk); aux_in[9] = 1'b1;
        tick(2);
        expect_val("R8 direct rising event core2", 4, 1);
        expect_val("R3 core1 event mask clear", 3, 0);
        tick(1);
        expect_val("R8 direct event one cycle", 4, 0);

        tick(2);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule